// File: doc/BRIEF.md
# Dual index and stack pointer unit

This unit is the register and addressing slice of a byte-wide datapath whose nominal data type is a 16-bit word. It holds two 16-bit index registers, W and IP, and two 8-bit stack pointers, one for the parameter stack and one for the return stack. Each clock cycle it takes one 8-bit microinstruction. Move microinstructions transfer one byte at a time, so a word reaches an index register or a stack slot as two moves. An instruction bit picks the high or the low byte lane. Step microinstructions increment or decrement one pointer. A further form loads the interrupt enable flip-flop.

The unit drives combinational read and write addresses for a shared 10-bit stack memory and for a 16-bit data memory, and it places the selected index byte on `idx_rd_o`. The move bus `move_data_i` carries the byte that the surrounding datapath has selected as the move source. The opcode latch and the ALU operands are outside this unit. When a move names them as its destination, the unit only drives the source side of that move.

Top module: `dual_ptr_unit`

## Requirements
- R1: For a move (bit 7 = 0) whose source field (bits 5:3) is 0 (W) or 1 (IP), `idx_rd_o` carries the high byte of that register when bit 6 = 1 and the low byte when bit 6 = 0.
- R2: A move whose destination field (bits 2:0) is 0 (W) or 1 (IP) writes `move_data_i` into the lane picked by bit 6 and leaves the other byte of that register unchanged.
- R3: For a move with source 2 (parameter stack) or 3 (return stack), `stk_rd_en_o` is high and `stk_rd_addr_o` is {source bit 3, that stack's pointer, bit 6}. Address bit 9 = 1 selects the return stack, bits 8:1 hold the pointer and bit 0 is the byte lane.
- R4: For a move with destination 2 or 3, `stk_we_o` is high and `stk_wr_addr_o` is {destination bit 0, that stack's pointer, bit 6}.
- R5: A move with source 4 or 5 raises `dm_rd_en_o`, with `dm_rd_addr_o` equal to W or to IP. A move with destination 4 raises `dm_we_o`, with `dm_wr_addr_o` equal to W.
- R6: An instruction 0x80..0x8F with bit 2 = 0 and bit 1 = 0 increments (bit 3 = 1) or decrements (bit 3 = 0) W (bit 0 = 0) or IP (bit 0 = 1), wrapping modulo 65536.
- R7: An instruction 0x80..0x8F with bit 2 = 0 and bit 1 = 1 steps the parameter (bit 0 = 0) or return (bit 0 = 1) stack pointer, wrapping modulo 256. Each stack therefore spans 256 word slots.
- R8: An instruction 0x80..0x8F with bit 2 = 1 loads bit 3 into the interrupt enable flip-flop `irq_en_o`.
- R9: Reset clears both stack pointers, both index registers and the interrupt enable.
- R10: The stack pointers change only under R7. Moves and instructions 0x90..0xFF leave every register of the unit unchanged, except for the index byte written under R2.
- R11: `stk_we_o` and `dm_we_o` are never high together, and both are low for every instruction that is not a move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 8 | Current microinstruction |
| move_data_i | input | BYTE_W | Byte on the move bus |
| idx_rd_o | output | BYTE_W | Selected index register byte |
| stk_rd_en_o | output | 1 | Stack memory read enable |
| stk_rd_addr_o | output | SP_W+2 | Stack memory read address |
| stk_we_o | output | 1 | Stack memory write strobe |
| stk_wr_addr_o | output | SP_W+2 | Stack memory write address |
| dm_rd_en_o | output | 1 | Data memory read enable |
| dm_rd_addr_o | output | IDX_W | Data memory read address |
| dm_we_o | output | 1 | Data memory write strobe |
| dm_wr_addr_o | output | IDX_W | Data memory write address |
| irq_en_o | output | 1 | Interrupt enable flip-flop |

## Verification
Several properties are checked on every cycle. Stack writes carry the correct lane and pointer, data memory writes are addressed by W, and the two strobes never coincide. The stack pointers hold unless a stack step is decoded, a high-byte write to W preserves its low byte, a parameter stack increment adds exactly one, and the interrupt enable follows bit 3. Other behaviour can only be shown by the bench's scenarios. These are the wraparound of the index registers at 16 bits, the wrap of the stack addresses at 256 entries in both directions, word pushes and pops built from byte pairs, and the read-back of index bytes after mixed sequences of writes and steps.

// File: rtl/dual_ptr_pkg.sv
package dual_ptr_pkg;

   typedef enum logic [2:0] {
      SRC_W    = 3'd0,
      SRC_IP   = 3'd1,
      SRC_PSTK = 3'd2,
      SRC_RSTK = 3'd3,
      SRC_MW   = 3'd4,
      SRC_MIP  = 3'd5,
      SRC_ZERO = 3'd6,
      SRC_ALU  = 3'd7
   } src_e;

   typedef enum logic [2:0] {
      DST_W    = 3'd0,
      DST_IP   = 3'd1,
      DST_PSTK = 3'd2,
      DST_RSTK = 3'd3,
      DST_MW   = 3'd4,
      DST_OPL  = 3'd5,
      DST_OPA  = 3'd6,
      DST_OPB  = 3'd7
   } dst_e;

   typedef struct packed {
      logic is_move;   // class 0x00..0x7F
      logic is_step;   // class 0x80..0x8F, bit 2 clear
      logic is_ie;     // class 0x80..0x8F, bit 2 set
      logic hi;        // byte lane
      src_e src;
      dst_e dst;
      logic up;        // step direction or enable value
      logic on_sp;     // step targets a stack pointer
      logic sel;       // which member of the pair
   } dec_t;

endpackage

// File: rtl/dual_ptr_decode.sv
module dual_ptr_decode
   import dual_ptr_pkg::*;
(
   input  logic [7:0] instr_i,
   output dec_t       dec_o
);

   logic step_class;

   always_comb begin
      step_class    = (instr_i[7:4] == 4'h8);
      dec_o.is_move = ~instr_i[7];
      dec_o.is_step = step_class & ~instr_i[2];
      dec_o.is_ie   = step_class & instr_i[2];
      dec_o.hi      = instr_i[6];
      dec_o.src     = src_e'(instr_i[5:3]);
      dec_o.dst     = dst_e'(instr_i[2:0]);
      dec_o.up      = instr_i[3];
      dec_o.on_sp   = instr_i[1];
      dec_o.sel     = instr_i[0];
   end

endmodule

// File: rtl/dual_ptr_index.sv
module dual_ptr_index #(
   parameter int IDX_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              step_en,
   input  logic              step_up,
   output logic [IDX_W-1:0]  q
);

   logic [IDX_W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (step_en) begin
         nxt = step_up ? q + IDX_W'(1) : q - IDX_W'(1);
      end else if (wr_en) begin
         if (wr_hi) nxt[IDX_W-1:BYTE_W] = wr_byte;
         else       nxt[BYTE_W-1:0]     = wr_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/dual_ptr_stack.sv
module dual_ptr_stack #(
   parameter int SP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  logic            step_up,
   output logic [SP_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (step_en) q <= step_up ? q + SP_W'(1) : q - SP_W'(1);
   end

endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
   import dual_ptr_pkg::*;
#(
   parameter int IDX_W  = 16,
   parameter int SP_W   = 8,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        instr_i,
   input  logic [BYTE_W-1:0] move_data_i,
   output logic [BYTE_W-1:0] idx_rd_o,
   output logic              stk_rd_en_o,
   output logic [SP_W+1:0]   stk_rd_addr_o,
   output logic              stk_we_o,
   output logic [SP_W+1:0]   stk_wr_addr_o,
   output logic              dm_rd_en_o,
   output logic [IDX_W-1:0]  dm_rd_addr_o,
   output logic              dm_we_o,
   output logic [IDX_W-1:0]  dm_wr_addr_o,
   output logic              irq_en_o
);

   localparam int NPAIR  = 2;
   localparam int STK_AW = SP_W + 2;

   if (IDX_W != 2 * BYTE_W) begin : g_bad_idx
      $error("dual_ptr_unit: IDX_W must be two byte lanes");
   end
   if (SP_W < 1) begin : g_bad_sp
      $error("dual_ptr_unit: SP_W must be positive");
   end

   dec_t dec;
   logic [NPAIR-1:0][IDX_W-1:0] idx_q;
   logic [NPAIR-1:0][SP_W-1:0]  sp_q;
   logic                        ie_q;

   dual_ptr_decode u_dec (
      .instr_i (instr_i),
      .dec_o   (dec)
   );

   for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      dual_ptr_index #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_idx (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (dec.is_move && dec.dst[2:1] == 2'b00 && dec.dst[0] == 1'(i)),
         .wr_hi   (dec.hi),
         .wr_byte (move_data_i),
         .step_en (dec.is_step && !dec.on_sp && dec.sel == 1'(i)),
         .step_up (dec.up),
         .q       (idx_q[i])
      );
      dual_ptr_stack #(.SP_W(SP_W)) u_sp (
         .clk     (clk),
         .rst_n   (rst_n),
         .step_en (dec.is_step && dec.on_sp && dec.sel == 1'(i)),
         .step_up (dec.up),
         .q       (sp_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         ie_q <= 1'b0;
      else if (dec.is_ie) ie_q <= dec.up;
   end

   always_comb begin
      idx_rd_o      = dec.hi ? idx_q[dec.src[0]][IDX_W-1:BYTE_W]
                             : idx_q[dec.src[0]][BYTE_W-1:0];
      stk_rd_en_o   = dec.is_move && (dec.src == SRC_PSTK || dec.src == SRC_RSTK);
      stk_rd_addr_o = STK_AW'({dec.src[0], sp_q[dec.src[0]], dec.hi});
      dm_rd_en_o    = dec.is_move && (dec.src == SRC_MW || dec.src == SRC_MIP);
      dm_rd_addr_o  = idx_q[dec.src[0]];
      stk_we_o      = dec.is_move && (dec.dst == DST_PSTK || dec.dst == DST_RSTK);
      stk_wr_addr_o = STK_AW'({dec.dst[0], sp_q[dec.dst[0]], dec.hi});
      dm_we_o       = dec.is_move && dec.dst == DST_MW;
      dm_wr_addr_o  = idx_q[0];
      irq_en_o      = ie_q;
   end

endmodule

// File: rtl/dual_ptr_unit_chk.sv
module dual_ptr_unit_chk #(
   parameter int IDX_W  = 16,
   parameter int SP_W   = 8,
   parameter int BYTE_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       instr_i,
   input logic             stk_we_o,
   input logic [SP_W+1:0]  stk_wr_addr_o,
   input logic             dm_we_o,
   input logic [IDX_W-1:0] dm_wr_addr_o,
   input logic             irq_en_o,
   input logic [IDX_W-1:0] w_q,
   input logic [SP_W-1:0]  psp,
   input logic [SP_W-1:0]  rsp
);

   p_wr_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we_o |-> (stk_wr_addr_o[0] == instr_i[6] && stk_wr_addr_o[SP_W+1] == instr_i[0]));

   p_wr_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we_o |-> stk_wr_addr_o[SP_W:1] == (instr_i[0] ? rsp : psp));

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_we_o, dm_we_o}));

   p_dm_wr_w_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dm_we_o |-> dm_wr_addr_o == w_q);

   p_sp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_i[7:4] == 4'h8 && instr_i[2:1] == 2'b01) |=> ($stable(psp) && $stable(rsp)));

   p_psp_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      instr_i == 8'h8A |=> psp == SP_W'($past(psp) + 1'b1));

   p_ie_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[7:4] == 4'h8 && instr_i[2]) |=> irq_en_o == $past(instr_i[3]));

   p_w_keep_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_i[7] && instr_i[6] && instr_i[2:0] == 3'd0) |=>
         w_q[BYTE_W-1:0] == $past(w_q[BYTE_W-1:0]));

endmodule

bind dual_ptr_unit dual_ptr_unit_chk #(.IDX_W(IDX_W), .SP_W(SP_W), .BYTE_W(BYTE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .instr_i       (instr_i),
   .stk_we_o      (stk_we_o),
   .stk_wr_addr_o (stk_wr_addr_o),
   .dm_we_o       (dm_we_o),
   .dm_wr_addr_o  (dm_wr_addr_o),
   .irq_en_o      (irq_en_o),
   .w_q           (idx_q[0]),
   .psp           (sp_q[0]),
   .rsp           (sp_q[1])
);

// File: tb/dual_ptr_unit_tb_top.sv
module dual_ptr_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  instr_i = 8'hF0;
   logic [7:0]  move_data_i = 8'h00;
   logic [7:0]  idx_rd_o;
   logic        stk_rd_en_o, stk_we_o, dm_rd_en_o, dm_we_o, irq_en_o;
   logic [9:0]  stk_rd_addr_o, stk_wr_addr_o;
   logic [15:0] dm_rd_addr_o, dm_wr_addr_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [15:0] m_idx [2];
   logic [7:0]  m_sp  [2];
   logic        m_ie;
   logic [7:0]  stk_mem [1024];

   always #10 clk = ~clk;

   dual_ptr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .move_data_i(move_data_i),
      .idx_rd_o(idx_rd_o), .stk_rd_en_o(stk_rd_en_o), .stk_rd_addr_o(stk_rd_addr_o),
      .stk_we_o(stk_we_o), .stk_wr_addr_o(stk_wr_addr_o), .dm_rd_en_o(dm_rd_en_o),
      .dm_rd_addr_o(dm_rd_addr_o), .dm_we_o(dm_we_o), .dm_wr_addr_o(dm_wr_addr_o),
      .irq_en_o(irq_en_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [9:0] saddr(input logic which, input logic hi);
      return {which, m_sp[which], hi};
   endfunction

   function automatic logic [7:0] dmem_val(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] idx_byte(input logic which, input logic hi);
      return hi ? m_idx[which][15:8] : m_idx[which][7:0];
   endfunction

   function automatic string pick(input string tag, input string dflt);
      return (tag == "") ? dflt : tag;
   endfunction

   // One instruction: drive at negedge, check combinational outputs, update model at posedge
   task automatic run(input logic [7:0] ins, input logic [7:0] alu_val, input string tag);
      logic       mv, hi;
      logic [2:0] src, dst;
      logic [7:0] bus;
      mv  = ~ins[7];
      hi  = ins[6];
      src = ins[5:3];
      dst = ins[2:0];
      case (src)
         3'd0, 3'd1: bus = idx_byte(src[0], hi);
         3'd2, 3'd3: bus = stk_mem[saddr(src[0], hi)];
         3'd4, 3'd5: bus = dmem_val(m_idx[src[0]]);
         3'd6:       bus = 8'h00;
         default:    bus = alu_val;
      endcase
      @(negedge clk);
      instr_i = ins;
      move_data_i = bus;
      #5;
      if (mv && src[2:1] == 2'b00) chk(pick(tag, "R1"), idx_rd_o, idx_byte(src[0], hi));
      chk(pick(tag, "R3"), stk_rd_en_o, mv && src[2:1] == 2'b01);
      if (mv && src[2:1] == 2'b01) chk(pick(tag, "R3"), stk_rd_addr_o, saddr(src[0], hi));
      chk(pick(tag, "R5"), dm_rd_en_o, mv && src[2:1] == 2'b10);
      if (mv && src[2:1] == 2'b10) chk(pick(tag, "R5"), dm_rd_addr_o, m_idx[src[0]]);
      chk(pick(tag, "R11"), stk_we_o, mv && dst[2:1] == 2'b01);
      if (mv && dst[2:1] == 2'b01) chk(pick(tag, "R4"), stk_wr_addr_o, saddr(dst[0], hi));
      chk(pick(tag, "R11"), dm_we_o, mv && dst == 3'd4);
      if (mv && dst == 3'd4) chk(pick(tag, "R5"), dm_wr_addr_o, m_idx[0]);
      @(posedge clk);
      if (mv) begin
         if (dst[2:1] == 2'b00) begin
            if (hi) m_idx[dst[0]][15:8] = bus;
            else    m_idx[dst[0]][7:0]  = bus;
         end
         if (dst[2:1] == 2'b01) stk_mem[saddr(dst[0], hi)] = bus;
      end else if (ins[7:4] == 4'h8) begin
         if (ins[2]) m_ie = ins[3];
         else if (ins[1]) m_sp[ins[0]] = ins[3] ? m_sp[ins[0]] + 8'd1 : m_sp[ins[0]] - 8'd1;
         else m_idx[ins[0]] = ins[3] ? m_idx[ins[0]] + 16'd1 : m_idx[ins[0]] - 16'd1;
      end
      #1;
      chk(pick(tag, "R8"), irq_en_o, m_ie);
   endtask

   // Move encoding: {0, hi, src[2:0], dst[2:0]}
   function automatic logic [7:0] mov(input logic hi, input logic [2:0] src, input logic [2:0] dst);
      return {1'b0, hi, src, dst};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      m_idx[0] = '0; m_idx[1] = '0; m_sp[0] = '0; m_sp[1] = '0; m_ie = 1'b0;
      for (int i = 0; i < 1024; i++) stk_mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state seen through the ports
      @(negedge clk);
      instr_i = mov(1'b0, 3'd2, 3'd7); #5;
      chk("R9", stk_rd_addr_o, 10'h000);
      instr_i = mov(1'b1, 3'd3, 3'd7); #5;
      chk("R9", stk_rd_addr_o, 10'h201);
      instr_i = mov(1'b0, 3'd0, 3'd6); #5;
      chk("R9", idx_rd_o, 8'h00);
      instr_i = mov(1'b1, 3'd1, 3'd6); #5;
      chk("R9", idx_rd_o, 8'h00);
      chk("R9", irq_en_o, 1'b0);

      // R2: byte writes keep the other lane
      run(mov(1'b0, 3'd7, 3'd0), 8'h34, "R2");
      run(mov(1'b1, 3'd7, 3'd0), 8'h12, "R2");
      run(mov(1'b0, 3'd7, 3'd0), 8'hAB, "R2");
      run(mov(1'b1, 3'd0, 3'd6), 8'h00, "R2");
      run(mov(1'b0, 3'd0, 3'd6), 8'h00, "R2");

      // R6: index wrap at 16 bits, both directions
      run(mov(1'b0, 3'd7, 3'd0), 8'hFF, "R6");
      run(mov(1'b1, 3'd7, 3'd0), 8'hFF, "R6");
      run(8'h88, 8'h00, "R6");
      run(mov(1'b1, 3'd0, 3'd6), 8'h00, "R6");
      run(mov(1'b0, 3'd0, 3'd6), 8'h00, "R6");
      run(8'h81, 8'h00, "R6");
      run(mov(1'b1, 3'd1, 3'd6), 8'h00, "R6");
      run(mov(1'b0, 3'd1, 3'd6), 8'h00, "R6");

      // R7: parameter stack wraps below zero, word pushed as two bytes
      run(8'h82, 8'h00, "R7");
      run(mov(1'b0, 3'd7, 3'd2), 8'h3C, "R7");
      run(mov(1'b1, 3'd7, 3'd2), 8'hC3, "R7");
      run(mov(1'b0, 3'd2, 3'd1), 8'h00, "R7");
      run(mov(1'b1, 3'd2, 3'd1), 8'h00, "R7");
      run(mov(1'b0, 3'd1, 3'd6), 8'h00, "R7");
      run(8'h8A, 8'h00, "R7");
      run(8'h8A, 8'h00, "R7");
      run(mov(1'b0, 3'd2, 3'd7), 8'h00, "R7");
      // return stack wrap above 255
      for (int i = 0; i < 256; i++) run(8'h8B, 8'h00, "R7");
      run(mov(1'b1, 3'd0, 3'd3), 8'h00, "R7");
      run(8'h83, 8'h00, "R7");
      run(mov(1'b1, 3'd3, 3'd4), 8'h00, "R7");

      // R8: interrupt enable load
      run(8'h8C, 8'h00, "R8");
      run(8'h84, 8'h00, "R8");
      run(8'h8C, 8'h00, "R8");

      // R10: upper classes have no effect on the unit
      for (int i = 0; i < 40; i++) run(8'(8'h90 + $urandom_range(0, 111)), 8'h00, "R10");
      run(mov(1'b0, 3'd2, 3'd3), 8'h00, "R10");
      run(mov(1'b1, 3'd1, 3'd4), 8'h00, "R10");

      // Mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] ins;
         case ($urandom_range(0, 3))
            0, 1:    ins = {1'b0, 7'($urandom())};
            2:       ins = 8'(8'h80 + $urandom_range(0, 15));
            default: ins = 8'($urandom_range(144, 255));
         endcase
         run(ins, 8'($urandom()), "");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule